// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block keeps a fixed set of warp slots and sends one warp-wide instruction per cycle to a group of 32 execution lanes. A launch request gives a thread count and a start PC. The block cuts the threads into warps of 32 consecutive IDs: warp 0 takes threads 0 to 31, warp 1 takes 32 to 63, and so on. Each warp gets a 32-bit lane mask. A trailing partial warp still takes a whole slot, with only its populated lanes enabled.

Each cycle the scheduler picks one ready warp in round-robin order and presents its PC and active mask on the issue port. Instruction fetch sits outside the block. In the same cycle the fetch logic returns the kind of instruction found at that PC, along with branch data when the instruction is a branch. The scheduler uses this to advance the warp strictly in program order, with no prediction. A warp that issues a load waits for a completion tagged with its index. A warp that issues a barrier waits for a release pulse. A branch on which the active lanes disagree is serialised through a small per-warp stack of reconvergence frames. Other warps are not touched by it.

Top module: `simt_warp_sched`

## Requirements
- R1: After synchronous reset no warp is live and `issue_valid` is low.
- R2: A launch of N threads (counts above the slot capacity saturate) replaces all slot state. Warp w becomes live when 32w < N. Its lane l is active when 32w+l < N. Every live warp starts at the launch PC.
- R3: While any warp is ready, `issue_valid` is high and the port shows that warp's index, PC and non-empty active mask. `ins_kind` in the same cycle describes the issued instruction: 0 plain, 1 load, 2 barrier, 3 branch, 4 exit.
- R4: The issued warp is the first ready warp after the last issued warp, in increasing index order with wrap-around. After a launch the search starts at warp 0.
- R5: A plain, load or barrier instruction advances the warp PC by one. A branch taken by none of the active lanes advances it by one. A branch taken by all active lanes sets it to `br_target`. The PC changes in no other way, except as R8 describes.
- R6: After a load the warp is not eligible until `mem_done_valid` arrives with `mem_done_warp` equal to its index. A completion for another warp does not release it.
- R7: After a barrier the warp is not eligible until a `bar_release` pulse. One pulse frees every warp waiting at a barrier.
- R8: On a branch where only some active lanes are set in `br_taken`, the warp runs `br_target` with the taken lanes. When its PC reaches `br_reconv`, it runs the branch PC plus one with the remaining lanes. When that path reaches `br_reconv`, the warp resumes at `br_reconv` with the full pre-branch mask. Lanes outside the active mask never count. Nesting may go up to STACK_DEPTH levels.
- R9: Divergence in one warp leaves the PC and mask of every other warp unchanged, and those warps keep issuing.
- R10: An exit instruction retires the warp. When no warp is ready, `issue_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Start a new thread block; overrides all slots |
| launch_count | input | CNT_W (8) | Number of threads in the block |
| launch_pc | input | PC_W | Start PC for every warp |
| issue_valid | output | 1 | A warp instruction is issued this cycle |
| issue_warp | output | WID_W (2) | Index of the issued warp |
| issue_pc | output | PC_W | PC of the issued instruction |
| issue_mask | output | 32 | Active lanes of the issued instruction |
| ins_kind | input | 3 | Kind of the issued instruction (see R3) |
| br_taken | input | 32 | Per-lane branch outcome, for a branch |
| br_target | input | PC_W | Branch destination |
| br_reconv | input | PC_W | Reconvergence PC of the branch |
| mem_done_valid | input | 1 | A load result returned |
| mem_done_warp | input | WID_W (2) | Warp the load result belongs to |
| bar_release | input | 1 | Release all warps waiting at a barrier |

## Verification
Warp formation is tried with block sizes below, at and just above each multiple of 32, and at full capacity. This separates exact warp counts, partial trailing masks and empty slots. Issue order is tried with all warps ready for several rounds, which shows the wrap-around of the rotation. It is also tried with some warps stalled on loads or barriers, which shows that a completion for the wrong warp releases nothing. Branches are tried in four forms: uniform taken, uniform not taken, a genuine lane split, and a split whose taken path is empty. A further case has taken bits only on inactive lanes of a partial warp, which must not diverge. The split cases run next to a second warp whose PC and mask must stay unchanged.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;

    localparam int LANES = 32;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic [2:0] {
        OP_PLAIN  = 3'd0,
        OP_LOAD   = 3'd1,
        OP_BAR    = 3'd2,
        OP_BRANCH = 3'd3,
        OP_EXIT   = 3'd4
    } op_kind_t;

    // Lanes of warp 'warp' populated by a block of 'nthreads' threads.
    function automatic lane_mask_t launch_lanes(input int unsigned warp,
                                                input int unsigned nthreads);
        lane_mask_t m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            if ((warp * LANES + l) < nthreads) m[l] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/simt_rr_pick.sv
module simt_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    int idx;

    always_comb begin
        any  = 1'b0;
        pick = last;
        idx  = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last) + k) % N;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/simt_warp_slot.sv
module simt_warp_slot
    import simt_sched_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  lane_mask_t      launch_mask,
    input  logic [PC_W-1:0] launch_pc,
    input  logic            sel,
    input  op_kind_t        kind,
    input  lane_mask_t      br_taken,
    input  logic [PC_W-1:0] br_target,
    input  logic [PC_W-1:0] br_reconv,
    input  logic            mem_done,
    input  logic            bar_release,
    output logic            ready,
    output logic [PC_W-1:0] pc_o,
    output lane_mask_t      mask_o
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PC_W-1:0] rpc;
        logic [PC_W-1:0] alt_pc;
        lane_mask_t      alt_mask;
        lane_mask_t      join_mask;
        logic            second;
    } frame_t;

    frame_t          stk [DEPTH];
    logic            live, mem_wait, bar_wait;
    logic [PC_W-1:0] pc;
    lane_mask_t      mask;
    logic [SP_W-1:0] sp;

    logic [IDX_W-1:0] top_idx, wr_idx;
    lane_mask_t       taken, stay, n_mask;
    logic [PC_W-1:0]  pc_seq, pc_step, n_pc;
    logic             push, swap, pop, set_mem, set_bar, leave;
    frame_t           fresh, top;

    assign top_idx = IDX_W'(sp - 1'b1);
    assign wr_idx  = IDX_W'(sp);

    always_comb begin
        pc_seq  = pc + PC_W'(1);
        taken   = br_taken & mask;
        stay    = mask & ~taken;
        fresh   = '{rpc: br_reconv, alt_pc: pc_seq, alt_mask: stay,
                    join_mask: mask, second: 1'b0};
        pc_step = pc_seq;
        n_mask  = mask;
        push    = 1'b0;
        swap    = 1'b0;
        pop     = 1'b0;
        set_mem = 1'b0;
        set_bar = 1'b0;
        leave   = 1'b0;
        case (kind)
            OP_LOAD: set_mem = 1'b1;
            OP_BAR:  set_bar = 1'b1;
            OP_EXIT: leave   = 1'b1;
            OP_BRANCH: begin
                if (taken == '0) begin
                    pc_step = pc_seq;
                end else if (stay == '0) begin
                    pc_step = br_target;
                end else begin
                    pc_step = br_target;
                    n_mask  = taken;
                    push    = 1'b1;
                end
            end
            default: ;
        endcase
        top  = push ? fresh : stk[top_idx];
        n_pc = pc_step;
        if ((push || sp != '0) && !leave && pc_step == top.rpc) begin
            if (!top.second) begin
                swap   = 1'b1;
                n_pc   = top.alt_pc;
                n_mask = top.alt_mask;
            end else begin
                pop    = 1'b1;
                n_mask = top.join_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live     <= 1'b0;
            mem_wait <= 1'b0;
            bar_wait <= 1'b0;
            pc       <= '0;
            mask     <= '0;
            sp       <= '0;
        end else if (launch) begin
            live     <= |launch_mask;
            mem_wait <= 1'b0;
            bar_wait <= 1'b0;
            pc       <= launch_pc;
            mask     <= launch_mask;
            sp       <= '0;
        end else begin
            if (mem_done)    mem_wait <= 1'b0;
            if (bar_release) bar_wait <= 1'b0;
            if (sel) begin
                pc   <= n_pc;
                mask <= n_mask;
                if (leave)   live     <= 1'b0;
                if (set_mem) mem_wait <= 1'b1;
                if (set_bar) bar_wait <= 1'b1;
                if (push) begin
                    stk[wr_idx]        <= fresh;
                    stk[wr_idx].second <= swap;
                    sp                 <= sp + 1'b1;
                end else if (swap) begin
                    stk[top_idx].second <= 1'b1;
                end else if (pop) begin
                    sp <= sp - 1'b1;
                end
            end
        end
    end

    assign ready  = live & ~mem_wait & ~bar_wait;
    assign pc_o   = pc;
    assign mask_o = mask;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (sel && push && !launch) |-> (sp < SP_W'(DEPTH))); // R8
    AST_MASK_WITHIN: assert property (@(posedge clk) disable iff (rst)
        (sp != '0) |-> ((mask & ~stk[top_idx].join_mask) == '0)); // R8
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (sel && !launch && kind == OP_PLAIN && sp == '0) |=> (pc == $past(pc) + PC_W'(1))); // R5
    AST_EXIT_GONE: assert property (@(posedge clk) disable iff (rst)
        (sel && !launch && kind == OP_EXIT) |=> !ready); // R10

endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
    import simt_sched_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 2,
    localparam int WID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int CNT_W      = $clog2(NUM_WARPS * LANES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_valid,
    input  logic [CNT_W-1:0] launch_count,
    input  logic [PC_W-1:0]  launch_pc,
    output logic             issue_valid,
    output logic [WID_W-1:0] issue_warp,
    output logic [PC_W-1:0]  issue_pc,
    output logic [LANES-1:0] issue_mask,
    input  logic [2:0]       ins_kind,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             mem_done_valid,
    input  logic [WID_W-1:0] mem_done_warp,
    input  logic             bar_release
);
    op_kind_t            kind;
    logic [NUM_WARPS-1:0] ready_v;
    logic [PC_W-1:0]     pc_v   [NUM_WARPS];
    lane_mask_t          mask_v [NUM_WARPS];
    logic [WID_W-1:0]    last, pick;
    logic                any;

    assign kind = op_kind_t'(ins_kind);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        simt_warp_slot #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .launch      (launch_valid),
            .launch_mask (launch_lanes(w, int'(launch_count))),
            .launch_pc   (launch_pc),
            .sel         (any && pick == WID_W'(w)),
            .kind        (kind),
            .br_taken    (br_taken),
            .br_target   (br_target),
            .br_reconv   (br_reconv),
            .mem_done    (mem_done_valid && mem_done_warp == WID_W'(w)),
            .bar_release (bar_release),
            .ready       (ready_v[w]),
            .pc_o        (pc_v[w]),
            .mask_o      (mask_v[w])
        );
    end

    simt_rr_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick (
        .req  (ready_v),
        .last (last),
        .any  (any),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst || launch_valid) last <= WID_W'(NUM_WARPS - 1);
        else if (any)            last <= pick;
    end

    assign issue_valid = any;
    assign issue_warp  = pick;
    assign issue_pc    = pc_v[pick];
    assign issue_mask  = mask_v[pick];

    AST_ISSUE_LANES: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (issue_mask != '0)); // R3
    AST_LOAD_STALL: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && kind == OP_LOAD && !launch_valid)
        |=> !(issue_valid && issue_warp == $past(issue_warp))); // R6
    AST_BAR_STALL: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && kind == OP_BAR && !launch_valid)
        |=> !(issue_valid && issue_warp == $past(issue_warp))); // R7

endmodule

// File: tb/simt_warp_sched_bench.sv
module simt_warp_sched_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        launch_valid;
    logic [7:0]  launch_count;
    logic [15:0] launch_pc;
    logic        issue_valid;
    logic [1:0]  issue_warp;
    logic [15:0] issue_pc;
    logic [31:0] issue_mask;
    logic [2:0]  ins_kind;
    logic [31:0] br_taken;
    logic [15:0] br_target, br_reconv;
    logic        mem_done_valid;
    logic [1:0]  mem_done_warp;
    logic        bar_release;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [2:0] K_PLAIN = 3'd0, K_LOAD = 3'd1, K_BAR = 3'd2,
                           K_BR = 3'd3, K_EXIT = 3'd4;

    // block size, expected live warps
    localparam int FORM_TAB [8][2] = '{
        '{1, 1}, '{31, 1}, '{32, 1}, '{33, 2},
        '{64, 2}, '{65, 3}, '{100, 4}, '{128, 4}
    };

    always #5 clk = ~clk;

    simt_warp_sched u_simt_warp_sched (
        .clk(clk), .rst(rst), .launch_valid(launch_valid),
        .launch_count(launch_count), .launch_pc(launch_pc),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_pc(issue_pc), .issue_mask(issue_mask),
        .ins_kind(ins_kind), .br_taken(br_taken), .br_target(br_target),
        .br_reconv(br_reconv), .mem_done_valid(mem_done_valid),
        .mem_done_warp(mem_done_warp), .bar_release(bar_release)
    );

    function automatic logic [31:0] exp_mask(input int n, input int w);
        logic [31:0] m = '0;
        for (int l = 0; l < 32; l++) if (w * 32 + l < n) m[l] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic see(input string req, input int w, input int pc, input logic [31:0] m);
        chk({req, " valid"}, 64'(issue_valid), 64'(1));
        chk({req, " warp"},  64'(issue_warp),  64'(w));
        chk({req, " pc"},    64'(issue_pc),    64'(pc));
        chk({req, " mask"},  64'(issue_mask),  64'(m));
    endtask

    task automatic step(input logic [2:0] k, input logic [31:0] tk = '0,
                        input logic [15:0] tgt = '0, input logic [15:0] rcv = '0);
        ins_kind  = k;
        br_taken  = tk;
        br_target = tgt;
        br_reconv = rcv;
        @(negedge clk);
        mem_done_valid = 1'b0;
        bar_release    = 1'b0;
        ins_kind       = K_PLAIN;
    endtask

    task automatic launch(input int n, input int pc);
        launch_valid = 1'b1;
        launch_count = 8'(n);
        launch_pc    = 16'(pc);
        step(K_PLAIN);
        launch_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; launch_valid = 1'b0; launch_count = '0; launch_pc = '0;
        ins_kind = K_PLAIN; br_taken = '0; br_target = '0; br_reconv = '0;
        mem_done_valid = 1'b0; mem_done_warp = '0; bar_release = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", 64'(issue_valid), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 still idle", 64'(issue_valid), 64'(0));

        // R2 R4 R10: warp formation table
        for (int i = 0; i < 8; i++) begin
            launch(FORM_TAB[i][0], 'h100);
            for (int w = 0; w < FORM_TAB[i][1]; w++) begin
                see("R2 R4 form", w, 'h100, exp_mask(FORM_TAB[i][0], w));
                step(K_EXIT);
            end
            chk("R10 all retired", 64'(issue_valid), 64'(0));
        end

        // R4 R5: rotation with wrap, then uniform branches
        launch(128, 'h200);
        for (int k = 0; k < 6; k++) begin
            see("R4 rotation", k % 4, 'h200 + k / 4, '1);
            step(K_PLAIN);
        end
        see("R5 pre-taken", 2, 'h201, '1);
        step(K_BR, '1, 16'h300, 16'h3ff);
        see("R5 pre-nottaken", 3, 'h201, '1);
        step(K_BR, '0, 16'h300, 16'h3ff);
        see("R5 w0", 0, 'h202, '1); step(K_PLAIN);
        see("R5 w1", 1, 'h202, '1); step(K_PLAIN);
        see("R5 uniform taken", 2, 'h300, '1); step(K_PLAIN);
        see("R5 uniform not taken", 3, 'h202, '1); step(K_PLAIN);

        // R6: load stall, wrong-warp completion ignored
        launch(64, 0);
        see("R6 w0 load", 0, 0, '1); step(K_LOAD);
        see("R6 w1", 1, 0, '1);
        mem_done_valid = 1'b1; mem_done_warp = 2'd1;
        step(K_PLAIN);
        see("R6 w0 held after foreign completion", 1, 1, '1); step(K_PLAIN);
        see("R6 w1 again", 1, 2, '1);
        mem_done_valid = 1'b1; mem_done_warp = 2'd0;
        step(K_PLAIN);
        see("R6 w0 released", 0, 1, '1); step(K_PLAIN);

        launch(32, 'h10);
        see("R6 single", 0, 'h10, '1); step(K_LOAD);
        chk("R6 R10 nothing ready", 64'(issue_valid), 64'(0));
        @(negedge clk);
        chk("R6 still waiting", 64'(issue_valid), 64'(0));
        mem_done_valid = 1'b1; mem_done_warp = 2'd0;
        @(negedge clk);
        mem_done_valid = 1'b0;
        see("R6 resumed", 0, 'h11, '1);

        // R7: barrier
        launch(64, 0);
        see("R7 w0 bar", 0, 0, '1); step(K_BAR);
        see("R7 w1 bar", 1, 0, '1); step(K_BAR);
        chk("R7 both waiting", 64'(issue_valid), 64'(0));
        bar_release = 1'b1;
        step(K_PLAIN);
        see("R7 w0 freed", 0, 1, '1); step(K_PLAIN);
        see("R7 w1 freed", 1, 1, '1); step(K_PLAIN);

        // R8 R9: divergence
        launch(64, 'h10);
        see("R8 branch", 0, 'h10, '1); step(K_BR, 32'h0000ffff, 16'h20, 16'h30);
        see("R9 other warp", 1, 'h10, '1); step(K_PLAIN);
        see("R8 taken path", 0, 'h20, 32'h0000ffff); step(K_PLAIN);
        see("R9 w1", 1, 'h11, '1); step(K_PLAIN);
        see("R8 taken path 2", 0, 'h21, 32'h0000ffff); step(K_BR, '1, 16'h30, 16'h0);
        see("R9 w1 b", 1, 'h12, '1); step(K_PLAIN);
        see("R8 other path", 0, 'h11, 32'hffff0000); step(K_BR, '1, 16'h30, 16'h0);
        see("R9 w1 c", 1, 'h13, '1); step(K_PLAIN);
        see("R8 reconverged", 0, 'h30, '1); step(K_BR, 32'h1, 16'h40, 16'h40);
        see("R9 w1 d", 1, 'h14, '1); step(K_PLAIN);
        see("R8 empty taken path", 0, 'h31, 32'hfffffffe); step(K_BR, '1, 16'h40, 16'h0);
        see("R9 w1 e", 1, 'h15, '1); step(K_PLAIN);
        see("R8 reconverged 2", 0, 'h40, '1); step(K_PLAIN);

        // R8: taken bits only on inactive lanes of a partial warp
        launch(33, 0);
        see("R8 partial w0", 0, 0, '1); step(K_PLAIN);
        see("R8 partial w1", 1, 0, 32'h1); step(K_BR, 32'hfffffffe, 16'h50, 16'h60);
        see("R8 partial w0 b", 0, 1, '1); step(K_PLAIN);
        see("R8 inactive lanes ignored", 1, 1, 32'h1); step(K_EXIT);
        see("R10 w0 alone", 0, 2, '1); step(K_EXIT);
        chk("R10 idle", 64'(issue_valid), 64'(0));

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule